// File: doc/BRIEF.md
# Dual-Pointer Indirect Address Translator

This block sits between a small processor's register-file port and a 256-byte data memory. It holds two 8-bit pointers. Each pointer is paired with a window address that has no storage behind it. When the processor reads or writes a window address, the access is redirected to the location held in that window's pointer. After the access, the pointer can step up by one, step down by one, or stay where it is. A two-bit mode field per pointer selects which. A 4-bit bank value extends the address whenever the resolved location lies in a banked region. For indirect reads, the block also produces the zero-flag update.

The processor presents one source (read) address and one destination (write) address per cycle. Either one, or both, may be a window, so a memory-to-memory move through the pointers completes in a single cycle. The block also owns four register addresses: the two pointers, the mode register and the bank register. Every other address passes through to the memory port. The physical memory address is 12 bits wide, built as {bank, address} for banked locations and as {0, address} for all others.

Top module: `dual_ptr_xlate`

## Requirements
- R1: After reset, both pointers read 0x00, the mode register (address 0x04) reads 0x0A (both channels hold), and the bank register (address 0x0F) reads 0x00.
- R2: Pointer 0 at 0x01 and pointer 1 at 0x09 are read/write over all 8 bits. The mode register keeps bits [3:0] and the bank register keeps bits [3:0]; the upper four bits of both read as 0.
- R3: A read of window 0 (0x00) or window 1 (0x08) returns the contents of the location addressed by that channel's pointer. The zero-flag update strobe is raised, with its value 1 exactly when the returned byte is 0x00.
- R4: A write to a window stores the write data at the location addressed by that channel's pointer. If that location is one of the block's own registers, that register is written.
- R5: Mode register bits [1:0] control pointer 0 and bits [3:2] control pointer 1. Encoding 01 increments the pointer after each window access, 00 decrements it, and 10 or 11 leave it unchanged. A pointer whose window is not accessed does not change.
- R6: Pointer steps wrap modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF). A pointer step never affects the zero-flag value, which reflects only the data read.
- R7: When a pointer holds 0x00 or 0x08, a read through its window returns 0x00 with the zero-flag value 1. A write through it asserts no memory write and changes no register.
- R8: Resolved addresses 0x10–0x17 and 0x20–0xFF map to physical address {bank, addr}. All other addresses map to {0x0, addr}. Direct and indirect accesses are treated alike.
- R9: In one cycle, the source and destination may both be windows. Each channel used steps once, and both accesses see the pointer values from before the step.
- R10: A write that targets a pointer register in the same cycle as that pointer's auto-step takes priority. The pointer takes the written value.
- R11: The zero-flag update strobe is asserted only for reads of a window address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Source access valid |
| rd_addr | input | 8 | Source logical address |
| rd_data | output | 8 | Source read data (combinational) |
| wr_en | input | 1 | Destination access valid |
| wr_addr | input | 8 | Destination logical address |
| wr_data | input | 8 | Destination write data |
| zf_we | output | 1 | Zero-flag update strobe |
| zf_val | output | 1 | Zero-flag value to load |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | 12 | Physical read address |
| mem_rd_data | input | 8 | Memory read data (asynchronous) |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | 12 | Physical write address |
| mem_wr_data | output | 8 | Memory write data |

## Verification
The bench targets the following corner cases:
- **Wrapping steps.** A pointer at 0xFF is incremented and a pointer at 0x00 is decremented. A design that carries into a ninth bit, or sets the zero flag from the new pointer value, returns a wrong pointer or a false zero flag.
- **Pointer aimed at a window.** A pointer holding 0x00 or 0x08 is used for a read and for a write, with non-zero bytes placed at those physical locations. A design without the null guard returns those bytes, or overwrites them.
- **Dual-window moves.** Moves use both channels, and one case uses the same channel on both sides. A design that steps a shared pointer twice, or lets the write see the stepped pointer, lands at a wrong address.
- **Write during auto-step.** A pointer is written directly while it auto-steps. A design that gives the step priority over the write loses the written value.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned BW = 4;
  localparam int unsigned PW = AW + BW;
  localparam int unsigned NCH = 2;
  localparam int unsigned MW = 2;

  localparam logic [AW-1:0] WIN0_A = 8'h00;
  localparam logic [AW-1:0] PTR0_A = 8'h01;
  localparam logic [AW-1:0] MODE_A = 8'h04;
  localparam logic [AW-1:0] WIN1_A = 8'h08;
  localparam logic [AW-1:0] PTR1_A = 8'h09;
  localparam logic [AW-1:0] BANK_A = 8'h0F;

  localparam logic [AW-1:0] BNK_LO_START = 8'h10;
  localparam logic [AW-1:0] BNK_LO_END   = 8'h17;
  localparam logic [AW-1:0] BNK_HI_START = 8'h20;

  localparam logic [NCH*MW-1:0] MODE_RST = 4'b1010;

  typedef enum logic [MW-1:0] {
    STEP_DEC  = 2'b00,
    STEP_INC  = 2'b01,
    STEP_HOLD = 2'b10,
    STEP_KEEP = 2'b11
  } step_e;

  typedef enum logic [2:0] {
    TGT_MEM,
    TGT_NULL,
    TGT_PTR0,
    TGT_PTR1,
    TGT_MODE,
    TGT_BANK
  } tgt_e;

  function automatic logic in_bank_region(input logic [AW-1:0] a);
    return ((a >= BNK_LO_START) && (a <= BNK_LO_END)) || (a >= BNK_HI_START);
  endfunction
endpackage

// File: rtl/dpx_rst_sync.sv
module dpx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dpx_resolve.sv
module dpx_resolve
  import dpx_pkg::*;
(
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  ptr0_i,
  input  logic [AW-1:0]  ptr1_i,
  input  logic [BW-1:0]  bank_i,
  output logic [NCH-1:0] win_o,
  output tgt_e           tgt_o,
  output logic [PW-1:0]  phys_o
);
  logic [AW-1:0] eff;

  always_comb begin
    win_o = '0;
    eff   = addr_i;
    if (addr_i == WIN0_A) begin
      win_o[0] = 1'b1;
      eff      = ptr0_i;
    end else if (addr_i == WIN1_A) begin
      win_o[1] = 1'b1;
      eff      = ptr1_i;
    end
  end

  always_comb begin
    case (eff)
      WIN0_A, WIN1_A: tgt_o = TGT_NULL;
      PTR0_A:         tgt_o = TGT_PTR0;
      PTR1_A:         tgt_o = TGT_PTR1;
      MODE_A:         tgt_o = TGT_MODE;
      BANK_A:         tgt_o = TGT_BANK;
      default:        tgt_o = TGT_MEM;
    endcase
  end

  always_comb begin
    if (in_bank_region(eff)) phys_o = {bank_i, eff};
    else                     phys_o = {{BW{1'b0}}, eff};
  end
endmodule

// File: rtl/dpx_chan.sv
module dpx_chan
  import dpx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  input  logic          used_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = load_i | used_i;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (used_i) begin
      case (step_e'(mode_i))
        STEP_INC: ptr_d = ptr_q + 1'b1;
        STEP_DEC: ptr_d = ptr_q - 1'b1;
        default:  ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dual_ptr_xlate.sv
module dual_ptr_xlate
  import dpx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [7:0]    rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          zf_we,
  output logic          zf_val,
  output logic          mem_rd_en,
  output logic [11:0]   mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [11:0]   mem_wr_addr,
  output logic [7:0]    mem_wr_data
);
  logic              rst_sync_n;
  logic [AW-1:0]     ptr [NCH];
  logic [NCH*MW-1:0] mode_q, mode_d;
  logic              mode_en;
  logic [BW-1:0]     bank_q, bank_d;
  logic              bank_en;
  logic [NCH-1:0]    rd_win, wr_win;
  tgt_e              rd_tgt, wr_tgt;
  logic [PW-1:0]     rd_phys, wr_phys;

  dpx_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dpx_resolve u_res_rd (
    .addr_i (rd_addr),
    .ptr0_i (ptr[0]),
    .ptr1_i (ptr[1]),
    .bank_i (bank_q),
    .win_o  (rd_win),
    .tgt_o  (rd_tgt),
    .phys_o (rd_phys)
  );

  dpx_resolve u_res_wr (
    .addr_i (wr_addr),
    .ptr0_i (ptr[0]),
    .ptr1_i (ptr[1]),
    .bank_i (bank_q),
    .win_o  (wr_win),
    .tgt_o  (wr_tgt),
    .phys_o (wr_phys)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam tgt_e OWN_TGT = (g == 0) ? TGT_PTR0 : TGT_PTR1;
    logic used, load;
    always_comb begin
      used = (rd_en & rd_win[g]) | (wr_en & wr_win[g]);
      load = wr_en & (wr_tgt == OWN_TGT);
    end
    dpx_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .mode_i     (mode_q[g*MW +: MW]),
      .used_i     (used),
      .load_i     (load),
      .load_val_i (wr_data),
      .ptr_o      (ptr[g])
    );
  end

  always_comb begin
    mode_en = wr_en & (wr_tgt == TGT_MODE);
    mode_d  = wr_data[NCH*MW-1:0];
    bank_en = wr_en & (wr_tgt == TGT_BANK);
    bank_d  = wr_data[BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MODE_RST;
      bank_q <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (bank_en) bank_q <= bank_d;
    end
  end

  always_comb begin
    case (rd_tgt)
      TGT_NULL: rd_data = '0;
      TGT_PTR0: rd_data = ptr[0];
      TGT_PTR1: rd_data = ptr[1];
      TGT_MODE: rd_data = {{(AW-NCH*MW){1'b0}}, mode_q};
      TGT_BANK: rd_data = {{(AW-BW){1'b0}}, bank_q};
      default:  rd_data = mem_rd_data;
    endcase
    zf_we       = rd_en & (|rd_win);
    zf_val      = (rd_data == '0);
    mem_rd_en   = rd_en & (rd_tgt == TGT_MEM);
    mem_rd_addr = rd_phys;
    mem_wr_en   = wr_en & (wr_tgt == TGT_MEM);
    mem_wr_addr = wr_phys;
    mem_wr_data = wr_data;
  end
endmodule

// File: rtl/dual_ptr_xlate_chk.sv
module dual_ptr_xlate_chk
  import dpx_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [7:0]    rd_addr,
  input logic [7:0]    rd_data,
  input logic          wr_en,
  input logic [7:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          zf_we,
  input logic          zf_val,
  input logic          mem_rd_en,
  input logic [11:0]   mem_rd_addr,
  input logic          mem_wr_en,
  input logic [7:0]    ptr0,
  input logic [7:0]    ptr1,
  input logic [3:0]    mode,
  input logic [3:0]    bank
);
  logic wr_hits_ptr0;
  always_comb wr_hits_ptr0 = wr_en && ((wr_addr == PTR0_A) ||
                             ((wr_addr == WIN0_A) && (ptr0 == PTR0_A)) ||
                             ((wr_addr == WIN1_A) && (ptr1 == PTR0_A)));

  AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == WIN0_A) && ((ptr0 == WIN0_A) || (ptr0 == WIN1_A)))
      |-> (rd_data == 8'h00) && zf_we && zf_val); // R7

  AST_NULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == WIN1_A) && ((ptr1 == WIN0_A) || (ptr1 == WIN1_A)))
      |-> !mem_wr_en); // R7

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == WIN0_A) && (mode[1:0] == 2'b01) && !wr_hits_ptr0)
      |=> (ptr0 == $past(ptr0) + 8'd1)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> $stable(ptr1)); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == PTR0_A)) |=> (ptr0 == $past(wr_data))); // R10

  AST_ZF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    zf_we |-> (rd_en && ((rd_addr == WIN0_A) || (rd_addr == WIN1_A)))); // R11

  AST_BANK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && (rd_addr >= BNK_HI_START)) |-> (mem_rd_addr == {bank, rd_addr})); // R8
endmodule

bind dual_ptr_xlate dual_ptr_xlate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .zf_we       (zf_we),
  .zf_val      (zf_val),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_en   (mem_wr_en),
  .ptr0        (ptr[0]),
  .ptr1        (ptr[1]),
  .mode        (mode_q),
  .bank        (bank_q)
);

// File: tb/sim_dual_ptr_xlate.sv
module sim_dual_ptr_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [7:0]  rd_addr, wr_addr, wr_data, rd_data, mem_wr_data, mem_rd_data;
  logic        zf_we, zf_val, mem_rd_en, mem_wr_en;
  logic [11:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem [0:4095];

  int checks = 0;
  int errors = 0;
  logic [7:0] c_rd;
  logic       c_zwe, c_zv, c_mwe;

  always #5 clk = ~clk;

  dual_ptr_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .zf_we(zf_we), .zf_val(zf_val),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  assign mem_rd_data = mem[mem_rd_addr];
  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic re, input logic [7:0] ra, input logic we,
                     input logic [7:0] wa, input logic [7:0] wd);
    @(negedge clk);
    rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    c_rd = rd_data; c_zwe = zf_we; c_zv = zf_val; c_mwe = mem_wr_en;
    @(posedge clk);
    #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1'b1, a, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b0, 8'h00, 1'b1, a, d);
  endtask

  task automatic t_reset;
    rd(8'h01); chk("R1 ptr0", c_rd, 8'h00);
    rd(8'h09); chk("R1 ptr1", c_rd, 8'h00);
    rd(8'h04); chk("R1 mode", c_rd, 8'h0A);
    rd(8'h0F); chk("R1 bank", c_rd, 8'h00);
  endtask

  task automatic t_regs;
    wr(8'h04, 8'hF5); rd(8'h04); chk("R2 mode", c_rd, 8'h05);
    wr(8'h0F, 8'hA3); rd(8'h0F); chk("R2 bank", c_rd, 8'h03);
    wr(8'h01, 8'h5C); rd(8'h01); chk("R2 ptr0", c_rd, 8'h5C);
    wr(8'h09, 8'hC5); rd(8'h09); chk("R2 ptr1", c_rd, 8'hC5);
    wr(8'h04, 8'h0A); wr(8'h0F, 8'h00);
  endtask

  task automatic t_ind_read;
    wr(8'h01, 8'h05); mem[12'h005] = 8'h5A;
    rd(8'h00);
    chk("R3 data", c_rd, 8'h5A);
    chk("R3 zf_we", {7'd0, c_zwe}, 8'h01);
    chk("R3 zf nonzero", {7'd0, c_zv}, 8'h00);
    mem[12'h005] = 8'h00;
    rd(8'h00);
    chk("R3 zf zero", {7'd0, c_zv}, 8'h01);
    rd(8'h05);
    chk("R11 direct no zf", {7'd0, c_zwe}, 8'h00);
    rd(8'h01); chk("R5 hold10", c_rd, 8'h05);
  endtask

  task automatic t_ind_write;
    wr(8'h09, 8'h06);
    wr(8'h08, 8'h77);
    chk("R4 mem", mem[12'h006], 8'h77);
    rd(8'h09); chk("R4 ptr1 hold", c_rd, 8'h06);
    wr(8'h09, 8'h01);
    wr(8'h08, 8'h3C);
    rd(8'h01); chk("R4 reg target", c_rd, 8'h3C);
  endtask

  task automatic t_modes;
    wr(8'h04, 8'h01);
    wr(8'h01, 8'hFF); mem[12'h0FF] = 8'h33;
    rd(8'h00); chk("R6 zf after wrap", {7'd0, c_zv}, 8'h00);
    rd(8'h01); chk("R6 inc wrap", c_rd, 8'h00);
    wr(8'h09, 8'h03); mem[12'h003] = 8'h10;
    rd(8'h08); chk("R3 ptr1 data", c_rd, 8'h10);
    rd(8'h09); chk("R5 dec", c_rd, 8'h02);
    wr(8'h09, 8'h00);
    rd(8'h08);
    rd(8'h09); chk("R6 dec wrap", c_rd, 8'hFF);
    wr(8'h04, 8'h0C);
    wr(8'h09, 8'h07);
    rd(8'h08);
    rd(8'h09); chk("R5 hold11", c_rd, 8'h07);
    wr(8'h01, 8'h02);
    rd(8'h00);
    rd(8'h01); chk("R5 dec ptr0", c_rd, 8'h01);
    wr(8'h04, 8'h0A);
  endtask

  task automatic t_null;
    wr(8'h01, 8'h08); mem[12'h008] = 8'h44;
    rd(8'h00);
    chk("R7 read zero", c_rd, 8'h00);
    chk("R7 zf set", {7'd0, c_zv}, 8'h01);
    wr(8'h09, 8'h00); mem[12'h000] = 8'h55;
    wr(8'h08, 8'h99);
    chk("R7 no mem_wr", {7'd0, c_mwe}, 8'h00);
    chk("R7 mem kept", mem[12'h000], 8'h55);
    rd(8'h09); chk("R7 ptr1 kept", c_rd, 8'h00);
    rd(8'h01); chk("R7 ptr0 kept", c_rd, 8'h08);
  endtask

  task automatic t_bank;
    wr(8'h0F, 8'h05);
    wr(8'h01, 8'h25); mem[12'h525] = 8'hC3; mem[12'h025] = 8'h11;
    rd(8'h00); chk("R8 indirect banked", c_rd, 8'hC3);
    mem[12'h512] = 8'hB1; mem[12'h012] = 8'h01;
    rd(8'h12); chk("R8 direct low bank", c_rd, 8'hB1);
    mem[12'h018] = 8'h2E; mem[12'h518] = 8'hEE;
    rd(8'h18); chk("R8 unbanked", c_rd, 8'h2E);
    wr(8'h09, 8'h30);
    wr(8'h08, 8'h4D);
    chk("R8 banked write", mem[12'h530], 8'h4D);
    wr(8'h0F, 8'h00);
  endtask

  task automatic t_dual;
    wr(8'h04, 8'h01);
    wr(8'h01, 8'h30); wr(8'h09, 8'h40); mem[12'h030] = 8'h21;
    cyc(1'b1, 8'h00, 1'b1, 8'h08, 8'h21);
    chk("R9 src data", c_rd, 8'h21);
    chk("R9 dst mem", mem[12'h040], 8'h21);
    rd(8'h01); chk("R9 ptr0 step", c_rd, 8'h31);
    rd(8'h09); chk("R9 ptr1 step", c_rd, 8'h3F);
    wr(8'h01, 8'h50); mem[12'h050] = 8'h12;
    cyc(1'b1, 8'h00, 1'b1, 8'h00, 8'h66);
    chk("R9 same chan read", c_rd, 8'h12);
    chk("R9 same chan write", mem[12'h050], 8'h66);
    rd(8'h01); chk("R9 single step", c_rd, 8'h51);
  endtask

  task automatic t_prio;
    wr(8'h04, 8'h01);
    wr(8'h01, 8'h60);
    cyc(1'b1, 8'h00, 1'b1, 8'h01, 8'h70);
    rd(8'h01); chk("R10 ptr0 load wins", c_rd, 8'h70);
    wr(8'h09, 8'h44);
    cyc(1'b1, 8'h08, 1'b1, 8'h09, 8'h90);
    rd(8'h09); chk("R10 ptr1 load wins", c_rd, 8'h90);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rd_en = 1'b0; wr_en = 1'b0; rd_addr = '0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset;
    t_regs;
    t_ind_read;
    t_ind_write;
    t_modes;
    t_null;
    t_bank;
    t_dual;
    t_prio;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule